// File: doc/BRIEF.md
# Dual-Accumulator Multiply-Accumulate Engine

This block is the arithmetic core of a signal-processing unit. Each cycle it can take two 16-bit operands and a command, form a product with a 17x17 signed multiplier, and combine it in a 41-bit adder/subtracter with one of two 40-bit accumulators. The command set covers plain multiply, negated multiply, squaring, the square of the operand difference, and the accumulating forms of these. It also covers commands that work between the two accumulators and take no operands. Control inputs choose integer or fractional product scaling and signed or unsigned operands. Saturation can be enabled for each accumulator separately, to either the 32-bit or the full 40-bit range.

A separate store path reads the middle 16 bits of either accumulator and presents them as one data word. It rounds the word by either of two rounding rules and can clamp it to the 16-bit signed range. The block reports 32-bit and 40-bit overflow for each accumulator, plus a sticky flag that records any accumulator clamp. Every command completes in one clock, and only the selected accumulator changes.

Top module: `mac_engine`

## Requirements
- R1: After reset both accumulators are zero and all four overflow flags and the sticky saturation flag are clear.
- R2: `opCode` 6 writes x*y to the target, 7 writes x*x, and 8 writes -(x*y). Each operand is extended to 17 bits, by sign when `signedMul`=1 and by zero when `signedMul`=0. The product is then sign-extended to 40 bits.
- R3: With `fracMode`=1 the product is doubled (shifted left by one) before it is used. With `fracMode`=0 it is used unshifted.
- R4: `opCode` 4 adds x*y to the target, 5 adds x*x, and 9 subtracts x*y from it.
- R5: `opCode` 2 writes (x-y)^2 to the target and 3 adds (x-y)^2 to it. The difference is taken on the extended operands.
- R6: `opCode` 1 clears the target. `opCode` 10 writes A+B to the target, 11 writes target minus the other accumulator, and 12 writes the negated target. These four ignore `xIn` and `yIn`.
- R7: `accSel`=0 targets A and `accSel`=1 targets B. The non-target accumulator never changes. With `opValid`=0, or with `opCode` 0 or 13 to 15, neither accumulator changes.
- R8: When saturation is enabled for the target and `superSat`=0, a result outside the 32-bit signed range is written as 0x007FFFFFFF or 0xFF80000000. The choice follows the sign of the exact result.
- R9: When saturation is enabled for the target and `superSat`=1, a result outside the 40-bit signed range is written as 0x7FFFFFFFFF or 0x8000000000. With saturation disabled, the exact result wraps to 40 bits.
- R10: Each write updates the target's `ovf32` flag, which is set when the exact result lies outside the 32-bit signed range. It also updates the target's `ovf40` flag, which is set when the exact result lies outside the 40-bit range. Both flags are taken before saturation.
- R11: `satSticky` sets on any accumulator clamp and stays set until reset. The store path never sets it.
- R12: `storeVal` is bits 31:16 of the accumulator chosen by `storeSel` (0 = A). With `convRound`=0, one is added when bit 15 is 1.
- R13: With `convRound`=1, rounding matches R12 except when bits 15:0 equal 0x8000. In that case one is added only when bit 16 is 1, so the result is even.
- R14: With `satStore`=1, a rounded value above 32767 gives 0x7FFF and a value below -32768 gives 0x8000. With `satStore`=0 the low 16 bits of the rounded value are output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| opValid | input | 1 | Command strobe |
| opCode | input | 4 | Command code |
| accSel | input | 1 | Target accumulator (0 = A, 1 = B) |
| xIn | input | 16 | First operand |
| yIn | input | 16 | Second operand |
| fracMode | input | 1 | Fractional product scaling |
| signedMul | input | 1 | Signed operand extension |
| convRound | input | 1 | Round-to-even on ties in the store path |
| satEnA | input | 1 | Saturation enable for A |
| satEnB | input | 1 | Saturation enable for B |
| satStore | input | 1 | Store value clamping |
| superSat | input | 1 | Saturate at 40 bits instead of 32 |
| storeSel | input | 1 | Store source (0 = A, 1 = B) |
| accA | output | 40 | Accumulator A |
| accB | output | 40 | Accumulator B |
| storeVal | output | 16 | Rounded, optionally clamped store word |
| ovfA32 | output | 1 | A exceeded 32-bit range on last write |
| ovfA40 | output | 1 | A exceeded 40-bit range on last write |
| ovfB32 | output | 1 | B exceeded 32-bit range on last write |
| ovfB40 | output | 1 | B exceeded 40-bit range on last write |
| satSticky | output | 1 | Sticky accumulator clamp flag |

## Verification
A directed phase covers the corner products first. The most negative operand squared in fractional mode separates the 32-bit clamp from no clamp. Small integer products that land exactly on a half-LSB tie separate the two rounding rules. Repeated accumulator-to-accumulator adds drive values past 2^39, and these are run with saturation off, at 32 bits and at 40 bits, to tell wrap from each clamp limit. A long random phase follows, with extreme-biased operands and every control bit toggling. It compares both accumulators, all flags and the store word against a behavioural integer model on every cycle, which exposes any swapped extension, scaling or target choice.

// File: rtl/mac_pkg.sv
package mac_pkg;

  typedef enum logic [3:0] {
    OP_NOP   = 4'd0,
    OP_CLR   = 4'd1,
    OP_ED    = 4'd2,
    OP_EDAC  = 4'd3,
    OP_MAC   = 4'd4,
    OP_SQRAC = 4'd5,
    OP_MPY   = 4'd6,
    OP_SQR   = 4'd7,
    OP_MPYN  = 4'd8,
    OP_MSC   = 4'd9,
    OP_ADD   = 4'd10,
    OP_SUB   = 4'd11,
    OP_NEG   = 4'd12
  } macOp_e;

  // Which operand pair feeds the multiplier
  typedef enum logic [1:0] {
    MUL_XY   = 2'd0,
    MUL_XX   = 2'd1,
    MUL_DIFF = 2'd2
  } mulSrc_e;

  // Second adder input
  typedef enum logic [1:0] {
    ADD_ZERO   = 2'd0,
    ADD_PROD   = 2'd1,
    ADD_OTHER  = 2'd2,
    ADD_TARGET = 2'd3
  } addSrc_e;

  typedef struct packed {
    logic    wrEn;      // write the target accumulator
    logic    baseTgt;   // first adder input is the target (else zero)
    addSrc_e addSrc;
    logic    subtract;  // base minus addend
    mulSrc_e mulSrc;
  } macStrobe_t;

endpackage

// File: rtl/mac_ctrl.sv
module mac_ctrl
  import mac_pkg::*;
(
  input  logic       opValid,
  input  logic [3:0] opCode,
  output macStrobe_t st
);

  always_comb begin
    st        = '0;
    st.mulSrc = MUL_XY;
    st.addSrc = ADD_ZERO;
    if (opValid) begin
      case (macOp_e'(opCode))
        OP_CLR: begin
          st.wrEn = 1'b1;
        end
        OP_ED: begin
          st.wrEn   = 1'b1;
          st.addSrc = ADD_PROD;
          st.mulSrc = MUL_DIFF;
        end
        OP_EDAC: begin
          st.wrEn    = 1'b1;
          st.baseTgt = 1'b1;
          st.addSrc  = ADD_PROD;
          st.mulSrc  = MUL_DIFF;
        end
        OP_MAC: begin
          st.wrEn    = 1'b1;
          st.baseTgt = 1'b1;
          st.addSrc  = ADD_PROD;
        end
        OP_SQRAC: begin
          st.wrEn    = 1'b1;
          st.baseTgt = 1'b1;
          st.addSrc  = ADD_PROD;
          st.mulSrc  = MUL_XX;
        end
        OP_MPY: begin
          st.wrEn   = 1'b1;
          st.addSrc = ADD_PROD;
        end
        OP_SQR: begin
          st.wrEn   = 1'b1;
          st.addSrc = ADD_PROD;
          st.mulSrc = MUL_XX;
        end
        OP_MPYN: begin
          st.wrEn     = 1'b1;
          st.addSrc   = ADD_PROD;
          st.subtract = 1'b1;
        end
        OP_MSC: begin
          st.wrEn     = 1'b1;
          st.baseTgt  = 1'b1;
          st.addSrc   = ADD_PROD;
          st.subtract = 1'b1;
        end
        OP_ADD: begin
          st.wrEn    = 1'b1;
          st.baseTgt = 1'b1;
          st.addSrc  = ADD_OTHER;
        end
        OP_SUB: begin
          st.wrEn     = 1'b1;
          st.baseTgt  = 1'b1;
          st.addSrc   = ADD_OTHER;
          st.subtract = 1'b1;
        end
        OP_NEG: begin
          st.wrEn     = 1'b1;
          st.addSrc   = ADD_TARGET;
          st.subtract = 1'b1;
        end
        default: st.wrEn = 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/mac_datapath.sv
module mac_datapath
  import mac_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ACC_W  = 40
) (
  input  logic              clk,
  input  logic              rstN,
  input  macStrobe_t        st,
  input  logic              accSel,
  input  logic [DATA_W-1:0] xIn,
  input  logic [DATA_W-1:0] yIn,
  input  logic              fracMode,
  input  logic              signedMul,
  input  logic              convRound,
  input  logic              satEnA,
  input  logic              satEnB,
  input  logic              satStore,
  input  logic              superSat,
  input  logic              storeSel,
  output logic [ACC_W-1:0]  accA,
  output logic [ACC_W-1:0]  accB,
  output logic [DATA_W-1:0] storeVal,
  output logic [1:0]        ovf32,
  output logic [1:0]        ovf40,
  output logic              satSticky
);

  localparam int MUL_W  = DATA_W + 1;
  localparam int PROD_W = 2 * MUL_W;
  localparam int SUM_W  = ACC_W + 1;
  localparam int NORM_W = 2 * DATA_W;
  localparam int UP_W   = ACC_W - DATA_W + 1;
  localparam int NUM_ACC = 2;

  localparam logic [ACC_W-1:0] NORM_MAX = {{(ACC_W-NORM_W+1){1'b0}}, {(NORM_W-1){1'b1}}};
  localparam logic [ACC_W-1:0] NORM_MIN = {{(ACC_W-NORM_W+1){1'b1}}, {(NORM_W-1){1'b0}}};
  localparam logic [ACC_W-1:0] FULL_MAX = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic [ACC_W-1:0] FULL_MIN = {1'b1, {(ACC_W-1){1'b0}}};
  localparam logic [DATA_W-1:0] HALF_LSB = {1'b1, {(DATA_W-1){1'b0}}};

  logic [ACC_W-1:0] accQ [NUM_ACC];
  logic [1:0]       ovf32Q, ovf40Q;
  logic             stickyQ;

  // ---------------- multiplier ----------------
  logic signed [MUL_W-1:0]  xExt, yExt, diff, mulA, mulB;
  logic signed [PROD_W-1:0] prod;
  logic [ACC_W-1:0]         prodWide, prodAcc;

  always_comb begin
    xExt = signedMul ? $signed({xIn[DATA_W-1], xIn}) : $signed({1'b0, xIn});
    yExt = signedMul ? $signed({yIn[DATA_W-1], yIn}) : $signed({1'b0, yIn});
    diff = xExt - yExt;
    case (st.mulSrc)
      MUL_XX:   begin mulA = xExt; mulB = xExt; end
      MUL_DIFF: begin mulA = diff; mulB = diff; end
      default:  begin mulA = xExt; mulB = yExt; end
    endcase
    prod     = mulA * mulB;
    prodWide = {{(ACC_W-PROD_W){prod[PROD_W-1]}}, prod};
    prodAcc  = fracMode ? {prodWide[ACC_W-2:0], 1'b0} : prodWide;
  end

  // ---------------- adder / subtracter ----------------
  logic [ACC_W-1:0] tgtAcc, othAcc;
  logic [SUM_W-1:0] baseIn, addIn, sum;
  logic [SUM_W-NORM_W:0] hiBits;
  logic sumOvf32, sumOvf40, satEn, overLim, doClamp;
  logic [ACC_W-1:0] nextVal;

  always_comb begin
    tgtAcc = accQ[accSel];
    othAcc = accQ[~accSel];
    baseIn = st.baseTgt ? {tgtAcc[ACC_W-1], tgtAcc} : '0;
    case (st.addSrc)
      ADD_PROD:   addIn = {prodAcc[ACC_W-1], prodAcc};
      ADD_OTHER:  addIn = {othAcc[ACC_W-1], othAcc};
      ADD_TARGET: addIn = {tgtAcc[ACC_W-1], tgtAcc};
      default:    addIn = '0;
    endcase
    sum      = st.subtract ? (baseIn - addIn) : (baseIn + addIn);
    hiBits   = sum[SUM_W-1:NORM_W-1];
    sumOvf40 = sum[SUM_W-1] ^ sum[SUM_W-2];
    sumOvf32 = !((&hiBits) || !(|hiBits));
    satEn    = accSel ? satEnB : satEnA;
    overLim  = superSat ? sumOvf40 : sumOvf32;
    doClamp  = satEn && overLim;
    if (doClamp) begin
      if (superSat) nextVal = sum[SUM_W-1] ? FULL_MIN : FULL_MAX;
      else          nextVal = sum[SUM_W-1] ? NORM_MIN : NORM_MAX;
    end else begin
      nextVal = sum[ACC_W-1:0];
    end
  end

  // ---------------- accumulator registers ----------------
  for (genvar g = 0; g < NUM_ACC; g++) begin : gAcc
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        accQ[g]   <= '0;
        ovf32Q[g] <= 1'b0;
        ovf40Q[g] <= 1'b0;
      end else if (st.wrEn && (accSel == 1'(g))) begin
        accQ[g]   <= nextVal;
        ovf32Q[g] <= sumOvf32;
        ovf40Q[g] <= sumOvf40;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   stickyQ <= 1'b0;
    else if (st.wrEn && doClamp) stickyQ <= 1'b1;
  end

  // ---------------- store path ----------------
  logic [ACC_W-1:0]  srcAcc;
  logic [DATA_W-1:0] srcLow;
  logic              roundInc;
  logic [UP_W-1:0]   upper, rounded;
  logic [UP_W-DATA_W:0] topBits;

  always_comb begin
    srcAcc = storeSel ? accQ[1] : accQ[0];
    srcLow = srcAcc[DATA_W-1:0];
    if (convRound && (srcLow == HALF_LSB)) roundInc = srcAcc[DATA_W];
    else                                   roundInc = srcLow[DATA_W-1];
    upper   = {srcAcc[ACC_W-1], srcAcc[ACC_W-1:DATA_W]};
    rounded = upper + UP_W'(roundInc);
    topBits = rounded[UP_W-1:DATA_W-1];
    if (satStore && !((&topBits) || !(|topBits)))
      storeVal = rounded[UP_W-1] ? {1'b1, {(DATA_W-1){1'b0}}} : {1'b0, {(DATA_W-1){1'b1}}};
    else
      storeVal = rounded[DATA_W-1:0];
  end

  assign accA      = accQ[0];
  assign accB      = accQ[1];
  assign ovf32     = ovf32Q;
  assign ovf40     = ovf40Q;
  assign satSticky = stickyQ;

  // ---------------- assertions ----------------
  // R7
  a_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(st.wrEn && !accSel) |=> $stable(accQ[0]));
  // R7
  b_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(st.wrEn && accSel) |=> $stable(accQ[1]));
  // R8
  norm_sat_chk: assert property (@(posedge clk) disable iff (!rstN)
    (st.wrEn && !accSel && satEnA && !superSat) |=>
      ((&accQ[0][ACC_W-1:NORM_W-1]) || !(|accQ[0][ACC_W-1:NORM_W-1])));
  // R10
  ovf_nest_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((ovf40Q & ~ovf32Q) == 2'b00));
  // R11
  sticky_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    stickyQ |=> stickyQ);
  // R13
  conv_even_chk: assert property (@(posedge clk) disable iff (!rstN)
    (convRound && !satStore && srcLow == HALF_LSB) |-> !storeVal[0]);

endmodule

// File: rtl/mac_engine.sv
module mac_engine
  import mac_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        opValid,
  input  logic [3:0]  opCode,
  input  logic        accSel,
  input  logic [15:0] xIn,
  input  logic [15:0] yIn,
  input  logic        fracMode,
  input  logic        signedMul,
  input  logic        convRound,
  input  logic        satEnA,
  input  logic        satEnB,
  input  logic        satStore,
  input  logic        superSat,
  input  logic        storeSel,
  output logic [39:0] accA,
  output logic [39:0] accB,
  output logic [15:0] storeVal,
  output logic        ovfA32,
  output logic        ovfA40,
  output logic        ovfB32,
  output logic        ovfB40,
  output logic        satSticky
);

  macStrobe_t strobe;
  logic [1:0] ovf32, ovf40;

  mac_ctrl u_ctrl (
    .opValid (opValid),
    .opCode  (opCode),
    .st      (strobe)
  );

  mac_datapath #(.DATA_W(16), .ACC_W(40)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .st        (strobe),
    .accSel    (accSel),
    .xIn       (xIn),
    .yIn       (yIn),
    .fracMode  (fracMode),
    .signedMul (signedMul),
    .convRound (convRound),
    .satEnA    (satEnA),
    .satEnB    (satEnB),
    .satStore  (satStore),
    .superSat  (superSat),
    .storeSel  (storeSel),
    .accA      (accA),
    .accB      (accB),
    .storeVal  (storeVal),
    .ovf32     (ovf32),
    .ovf40     (ovf40),
    .satSticky (satSticky)
  );

  assign ovfA32 = ovf32[0];
  assign ovfB32 = ovf32[1];
  assign ovfA40 = ovf40[0];
  assign ovfB40 = ovf40[1];

endmodule

// File: tb/mac_engine_bench.sv
module mac_engine_bench;

  localparam int C_CLR = 1, C_ED = 2, C_EDAC = 3, C_MAC = 4, C_SQRAC = 5, C_MPY = 6,
                 C_SQR = 7, C_MPYN = 8, C_MSC = 9, C_ADD = 10, C_SUB = 11, C_NEG = 12;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic opValid = 1'b0;
  logic [3:0] opCode = '0;
  logic accSel = 1'b0;
  logic [15:0] xIn = '0, yIn = '0;
  logic fracMode = 1'b0, signedMul = 1'b0, convRound = 1'b0;
  logic satEnA = 1'b0, satEnB = 1'b0, satStore = 1'b0, superSat = 1'b0, storeSel = 1'b0;
  logic [39:0] accA, accB;
  logic [15:0] storeVal;
  logic ovfA32, ovfA40, ovfB32, ovfB40, satSticky;

  int checks = 0;
  int fails = 0;

  // reference state
  longint mAcc [2];
  bit mO32 [2];
  bit mO40 [2];
  bit mSticky;
  string tagAcc [2];

  always #10 clk = ~clk;

  mac_engine u_mac_engine (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode), .accSel(accSel),
    .xIn(xIn), .yIn(yIn), .fracMode(fracMode), .signedMul(signedMul),
    .convRound(convRound), .satEnA(satEnA), .satEnB(satEnB), .satStore(satStore),
    .superSat(superSat), .storeSel(storeSel), .accA(accA), .accB(accB),
    .storeVal(storeVal), .ovfA32(ovfA32), .ovfA40(ovfA40), .ovfB32(ovfB32),
    .ovfB40(ovfB40), .satSticky(satSticky)
  );

  function automatic longint wrap40(longint v);
    return (v <<< 24) >>> 24;
  endfunction

  task automatic check(string tag, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic longint expStore();
    longint v, low, up, r;
    bit inc;
    v   = storeSel ? mAcc[1] : mAcc[0];
    low = v & 64'hFFFF;
    up  = v >>> 16;
    if (convRound && low == 64'h8000) inc = up[0];
    else                              inc = low[15];
    r = up + longint'(inc);
    if (satStore && r > 32767)  r = 32767;
    if (satStore && r < -32768) r = -32768;
    return r & 64'hFFFF;
  endfunction

  function automatic string storeTag();
    longint v, low, r;
    v   = storeSel ? mAcc[1] : mAcc[0];
    low = v & 64'hFFFF;
    r   = (v >>> 16) + longint'(low[15]);
    if (satStore && (r > 32767 || r < -32768)) return "R14";
    if (convRound && low == 64'h8000) return "R13";
    return "R12";
  endfunction

  task automatic checkAll();
    check(tagAcc[0], "accA", longint'(accA), mAcc[0] & 64'hFF_FFFF_FFFF);
    check(tagAcc[1], "accB", longint'(accB), mAcc[1] & 64'hFF_FFFF_FFFF);
    check("R10", "ovf flags", longint'({ovfB40, ovfB32, ovfA40, ovfA32}),
          longint'({mO40[1], mO32[1], mO40[0], mO32[0]}));
    check("R11", "satSticky", longint'(satSticky), longint'(mSticky));
    check(storeTag(), "storeVal", longint'(storeVal), expStore());
  endtask

  // Advance the model by the command currently on the inputs
  task automatic modelStep();
    longint xe, ye, d, p, tgt, oth, t, lim;
    int s;
    bit clamp;
    string tg;
    tagAcc[0] = "R7";
    tagAcc[1] = "R7";
    if (!opValid || opCode == 0 || opCode > 12) return;
    s  = accSel ? 1 : 0;
    xe = signedMul ? longint'($signed(xIn)) : longint'(xIn);
    ye = signedMul ? longint'($signed(yIn)) : longint'(yIn);
    d  = xe - ye;
    case (int'(opCode))
      C_SQRAC, C_SQR: p = xe * xe;
      C_ED, C_EDAC:   p = d * d;
      default:        p = xe * ye;
    endcase
    if (fracMode) p = p * 2;
    tgt = mAcc[s];
    oth = mAcc[1-s];
    case (int'(opCode))
      C_CLR:                 t = 0;
      C_ED, C_MPY, C_SQR:    t = p;
      C_MPYN:                t = -p;
      C_EDAC, C_MAC, C_SQRAC: t = tgt + p;
      C_MSC:                 t = tgt - p;
      C_ADD:                 t = tgt + oth;
      C_SUB:                 t = tgt - oth;
      default:               t = -tgt;
    endcase
    mO40[s] = (t > (longint'(1) <<< 39) - 1) || (t < -(longint'(1) <<< 39));
    mO32[s] = (t > (longint'(1) <<< 31) - 1) || (t < -(longint'(1) <<< 31));
    lim   = superSat ? 39 : 31;
    clamp = (s ? satEnB : satEnA) && ((t > (longint'(1) <<< lim) - 1) || (t < -(longint'(1) <<< lim)));
    if (clamp) begin
      mAcc[s] = (t < 0) ? -(longint'(1) <<< lim) : (longint'(1) <<< lim) - 1;
      mSticky = 1'b1;
      tg = superSat ? "R9" : "R8";
    end else begin
      mAcc[s] = wrap40(t);
      case (int'(opCode))
        C_CLR, C_ADD, C_SUB, C_NEG: tg = "R6";
        C_ED, C_EDAC:               tg = "R5";
        C_MAC, C_SQRAC, C_MSC:      tg = "R4";
        default:                    tg = fracMode ? "R3" : "R2";
      endcase
      if (!(s ? satEnB : satEnA) && mO40[s]) tg = "R9";
    end
    tagAcc[s] = tg;
  endtask

  // One command: drive at the falling edge, check the previous result, model it
  task automatic doOp(bit v, int op, bit sel, logic [15:0] x, logic [15:0] y,
                      bit fr, bit sg, bit cv, bit sa, bit sb, bit ss, bit sup, bit ssel);
    @(negedge clk);
    opValid = v; opCode = 4'(op); accSel = sel; xIn = x; yIn = y;
    fracMode = fr; signedMul = sg; convRound = cv; satEnA = sa; satEnB = sb;
    satStore = ss; superSat = sup; storeSel = ssel;
    #1;
    checkAll();
    modelStep();
  endtask

  function automatic logic [15:0] pickOperand();
    case ($urandom_range(0, 5))
      0: return 16'h8000;
      1: return 16'h7FFF;
      2: return 16'hFFFF;
      3: return 16'(($urandom_range(0, 6)));
      default: return 16'($urandom);
    endcase
  endfunction

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    mAcc[0] = 0; mAcc[1] = 0;
    mO32[0] = 0; mO32[1] = 0; mO40[0] = 0; mO40[1] = 0;
    mSticky = 0;
    tagAcc[0] = "R1"; tagAcc[1] = "R1";
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: reset state checked by the first doOp
    // R2: unsigned integer multiply landing on a rounding tie (R12/R13)
    doOp(1, C_MPY, 0, 16'h0001, 16'h8000, 0, 0, 0, 0, 0, 0, 0, 0);
    doOp(0, 0, 0, 16'h0, 16'h0, 0, 0, 1, 0, 0, 0, 0, 0);
    doOp(1, C_MPY, 1, 16'h0003, 16'h8000, 0, 0, 1, 0, 0, 0, 0, 1);
    doOp(0, 0, 0, 16'h0, 16'h0, 0, 0, 0, 0, 0, 0, 0, 1);
    // R3/R8: fractional most-negative squared, unclamped then clamped at 32 bits
    doOp(1, C_MPY, 0, 16'h8000, 16'h8000, 1, 1, 0, 0, 0, 0, 0, 0);
    doOp(1, C_MPY, 1, 16'h8000, 16'h8000, 1, 1, 0, 0, 1, 1, 0, 1);
    // R6: accumulator ops ignore operands
    doOp(1, C_ADD, 0, 16'hDEAD, 16'hBEEF, 0, 0, 0, 0, 0, 1, 0, 0);
    doOp(1, C_NEG, 1, 16'h1234, 16'h5678, 1, 1, 0, 0, 0, 1, 0, 1);
    doOp(1, C_SUB, 0, 16'hFFFF, 16'h0001, 0, 0, 0, 0, 0, 0, 0, 0);
    // R5: difference squared, unsigned extremes
    doOp(1, C_ED, 1, 16'h0000, 16'hFFFF, 0, 0, 0, 0, 0, 0, 0, 1);
    doOp(1, C_EDAC, 1, 16'h8000, 16'h7FFF, 1, 1, 0, 0, 0, 0, 0, 1);
    // R9: grow past 2^39 by repeated adds, with each saturation setting
    for (int m = 0; m < 3; m++) begin
      doOp(1, C_MPY, 0, 16'h7FFF, 16'h7FFF, 1, 1, 0, 0, 0, 0, 0, 0);
      doOp(1, C_MPY, 1, 16'h7FFF, 16'h7FFF, 1, 1, 0, 0, 0, 0, 0, 1);
      for (int k = 0; k < 24; k++)
        doOp(1, C_ADD, k % 2 == 1, 16'h0, 16'h0, 0, 0, 0, m > 0, m > 0, k % 3 == 0, m == 2, k % 2 == 1);
      doOp(1, C_NEG, 0, 16'h0, 16'h0, 0, 0, 0, m > 0, m > 0, 1, m == 2, 0);
    end
    doOp(1, C_CLR, 0, 16'h0, 16'h0, 0, 0, 0, 0, 0, 0, 0, 0);
    doOp(1, C_CLR, 1, 16'h0, 16'h0, 0, 0, 0, 0, 0, 0, 0, 0);
    // R4/R7: random commands with all controls toggling, including idle and undefined codes
    for (int i = 0; i < 4000; i++) begin
      doOp($urandom_range(0, 9) != 0, $urandom_range(0, 15), 1'($urandom), pickOperand(), pickOperand(),
           1'($urandom), 1'($urandom), 1'($urandom), $urandom_range(0, 3) != 0,
           $urandom_range(0, 3) != 0, 1'($urandom), 1'($urandom), 1'($urandom));
    end
    doOp(0, 0, 0, 16'h0, 16'h0, 0, 0, 0, 0, 0, 0, 0, 0);
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule